// File: doc/BRIEF.md
# Programmable Flag Offset Register Loader

This block holds the two thresholds that a FIFO's programmable flag logic compares against: an almost-empty offset and an almost-full offset, each 12 bits wide. It sits on the write-clock side of the FIFO. Each write-clock cycle it decodes a configuration-mode input together with the write enable. The result is either a normal FIFO write strobe, a load of the low 12 bits of the data bus into one offset register, or nothing.

A single one-bit pointer chooses which offset register a load cycle writes. It alternates between the two registers, one per load cycle. It is not cleared when configuration mode is left, so a later load session carries on with the register after the last one written. A second, independent pointer on the read clock walks the same alternating order to return the offsets on an 18-bit readback word, zero-extended. Readback treats the offsets as quasi-static configuration and does not synchronise multi-bit changes across the clocks.

Top module: `ofs_loader`

## Requirements
- R1: With cfgMode=1 and wrEn=1, a rising wrClk edge loads wrData[11:0] into the offset register chosen by the write pointer (pointer 0 = almost-empty, 1 = almost-full).
- R2: Successive load cycles alternate almost-empty, almost-full, almost-empty, and so on without end, one register per cycle.
- R3: With cfgMode=0 and wrEn=1, fifoWrite is 1 and neither offset changes. With wrEn=0, both offsets are unchanged at either cfgMode value. fifoWrite is 0 whenever cfgMode=1 or wrEn=0.
- R4: Leaving configuration mode keeps the write pointer. The next load session writes the register after the last one loaded.
- R5: An active-low rstN sets both offsets to the parameter OFS_DEFAULT and points both pointers at the almost-empty register.
- R6: With cfgMode=1 and rdEn=1, a rising rdClk edge places the register chosen by the read pointer on rdWord and advances that pointer in the same alternating order. Otherwise rdWord holds its value.
- R7: rdWord is the 12-bit offset zero-extended to 18 bits (bits 17:12 are 0), and it resets to all zeros.
- R8: Readback cycles do not move the write pointer, and load cycles do not move the read pointer.
- R9: fifoRead is 1 exactly when cfgMode=0 and rdEn=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| cfgMode | input | 1 | 1 selects offset register access, 0 selects normal FIFO traffic |
| wrEn | input | 1 | Write enable |
| rdEn | input | 1 | Read enable |
| wrData | input | 18 | Write data bus; bits 11:0 carry an offset value |
| fifoWrite | output | 1 | Normal FIFO write strobe |
| fifoRead | output | 1 | Normal FIFO read strobe |
| emptyOffset | output | 12 | Almost-empty threshold |
| fullOffset | output | 12 | Almost-full threshold |
| rdWord | output | 18 | Offset readback word |

## Verification
The bench builds the block with OFS_DEFAULT set to 0x01F, the small-depth default, instead of 0x07F. This shows that the reset value follows the parameter and that it differs from every value the bench loads. The 18-bit data width lets the bench drive non-zero bits above bit 11 during loads, so any leak of those bits into an offset or onto the readback word can be seen. Interrupted load sessions and interleaved readback then exercise both pointers across sessions and across clocks.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef struct packed {
    logic wrOfs;
    logic wrSel;
    logic rdOfs;
    logic rdSel;
  } ofsCtl_t;
endpackage

// File: rtl/ofs_ctrl.sv
module ofs_ctrl
  import ofs_pkg::*;
(
  input  logic    wrClk,
  input  logic    rdClk,
  input  logic    rstN,
  input  logic    cfgMode,
  input  logic    wrEn,
  input  logic    rdEn,
  output logic    fifoWrite,
  output logic    fifoRead,
  output ofsCtl_t ctl
);
  logic wrPtr;
  logic rdPtr;
  logic wrLoad;
  logic rdLoad;

  assign wrLoad = cfgMode & wrEn;
  assign rdLoad = cfgMode & rdEn;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) wrPtr <= 1'b0;
    else if (wrLoad) wrPtr <= ~wrPtr;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) rdPtr <= 1'b0;
    else if (rdLoad) rdPtr <= ~rdPtr;
  end

  assign fifoWrite = ~cfgMode & wrEn;
  assign fifoRead  = ~cfgMode & rdEn;

  always_comb begin
    ctl.wrOfs = wrLoad;
    ctl.wrSel = wrPtr;
    ctl.rdOfs = rdLoad;
    ctl.rdSel = rdPtr;
  end

  // R2: each load cycle moves the write pointer to the other register
  assert_wr_alternate_R2: assert property (@(posedge wrClk) disable iff (!rstN)
    (cfgMode && wrEn) |=> (ctl.wrSel != $past(ctl.wrSel)));

  // R4: outside load cycles the write pointer keeps its position
  assert_wr_hold_R4: assert property (@(posedge wrClk) disable iff (!rstN)
    !(cfgMode && wrEn) |=> $stable(ctl.wrSel));

  // R8: read pointer moves only on readback cycles
  assert_rd_hold_R8: assert property (@(posedge rdClk) disable iff (!rstN)
    !(cfgMode && rdEn) |=> $stable(ctl.rdSel));
endmodule

// File: rtl/ofs_datapath.sv
module ofs_datapath
  import ofs_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int OFS_W = 12,
  parameter logic [OFS_W-1:0] OFS_DEFAULT = 12'h07F
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  ofsCtl_t           ctl,
  input  logic [DATA_W-1:0] wrData,
  output logic [OFS_W-1:0]  emptyOffset,
  output logic [OFS_W-1:0]  fullOffset,
  output logic [DATA_W-1:0] rdWord
);
  localparam int NUM_REGS = 2;
  localparam int PAD_W = DATA_W - OFS_W;

  logic [OFS_W-1:0] ofsReg [NUM_REGS];

  for (genvar idx = 0; idx < NUM_REGS; idx++) begin : g_ofs
    always_ff @(posedge wrClk or negedge rstN) begin
      if (!rstN) ofsReg[idx] <= OFS_DEFAULT;
      else if (ctl.wrOfs && (ctl.wrSel == idx[0])) ofsReg[idx] <= wrData[OFS_W-1:0];
    end
  end

  assign emptyOffset = ofsReg[0];
  assign fullOffset  = ofsReg[1];

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) rdWord <= '0;
    else if (ctl.rdOfs) rdWord <= {{PAD_W{1'b0}}, ofsReg[ctl.rdSel]};
  end

  // R1: a load into the almost-empty slot captures the low data bits
  assert_load_empty_R1: assert property (@(posedge wrClk) disable iff (!rstN)
    (ctl.wrOfs && !ctl.wrSel) |=> (emptyOffset == $past(wrData[OFS_W-1:0])));

  // R1: a load into the almost-full slot captures the low data bits
  assert_load_full_R1: assert property (@(posedge wrClk) disable iff (!rstN)
    (ctl.wrOfs && ctl.wrSel) |=> (fullOffset == $past(wrData[OFS_W-1:0])));

  // R3: without a load cycle both offsets hold
  assert_no_load_R3: assert property (@(posedge wrClk) disable iff (!rstN)
    !ctl.wrOfs |=> ($stable(emptyOffset) && $stable(fullOffset)));

  // R6: readback holds outside readback cycles
  assert_rd_hold_R6: assert property (@(posedge rdClk) disable iff (!rstN)
    !ctl.rdOfs |=> $stable(rdWord));
endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
  import ofs_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int OFS_W = 12,
  parameter logic [OFS_W-1:0] OFS_DEFAULT = 12'h07F
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              cfgMode,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              fifoWrite,
  output logic              fifoRead,
  output logic [OFS_W-1:0]  emptyOffset,
  output logic [OFS_W-1:0]  fullOffset,
  output logic [DATA_W-1:0] rdWord
);
  ofsCtl_t ctl;

  ofs_ctrl u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .cfgMode(cfgMode), .wrEn(wrEn), .rdEn(rdEn),
    .fifoWrite(fifoWrite), .fifoRead(fifoRead), .ctl(ctl)
  );

  ofs_datapath #(.DATA_W(DATA_W), .OFS_W(OFS_W), .OFS_DEFAULT(OFS_DEFAULT)) u_dp (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .ctl(ctl), .wrData(wrData),
    .emptyOffset(emptyOffset), .fullOffset(fullOffset), .rdWord(rdWord)
  );

  // R7: readback is zero above the offset field
  assert_rd_zero_ext_R7: assert property (@(posedge rdClk) disable iff (!rstN)
    rdWord[DATA_W-1:OFS_W] == '0);
endmodule

// File: tb/tb_ofs_loader.sv
module tb_ofs_loader;
  logic wrClk, rdClk, rstN, cfgMode, wrEn, rdEn;
  logic [17:0] wrData;
  logic fifoWrite, fifoRead;
  logic [11:0] emptyOffset, fullOffset;
  logic [17:0] rdWord;
  int checks = 0;
  int fails = 0;

  ofs_loader #(.DATA_W(18), .OFS_W(12), .OFS_DEFAULT(12'h01F)) dut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .cfgMode(cfgMode),
    .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData), .fifoWrite(fifoWrite),
    .fifoRead(fifoRead), .emptyOffset(emptyOffset), .fullOffset(fullOffset),
    .rdWord(rdWord)
  );

  initial begin wrClk = 0; forever #5 wrClk = ~wrClk; end
  initial begin rdClk = 0; #2; forever #5 rdClk = ~rdClk; end

  typedef struct packed {
    logic cfg; logic we; logic [17:0] d;
    logic [11:0] e; logic [11:0] f; logic fw;
  } vec_t;

  // R1 R2 R3 R4 load sequence with session breaks
  localparam vec_t VECS [9] = '{
    '{1'b1, 1'b1, 18'h00123, 12'h123, 12'h01F, 1'b0},
    '{1'b1, 1'b1, 18'h3FABC, 12'h123, 12'hABC, 1'b0},
    '{1'b0, 1'b1, 18'h00555, 12'h123, 12'hABC, 1'b1},
    '{1'b1, 1'b0, 18'h00777, 12'h123, 12'hABC, 1'b0},
    '{1'b0, 1'b0, 18'h00888, 12'h123, 12'hABC, 1'b0},
    '{1'b1, 1'b1, 18'h150AA, 12'h0AA, 12'hABC, 1'b0},
    '{1'b0, 1'b1, 18'h00999, 12'h0AA, 12'hABC, 1'b1},
    '{1'b1, 1'b1, 18'h3C0FF, 12'h0AA, 12'h0FF, 1'b0},
    '{1'b1, 1'b1, 18'h00001, 12'h001, 12'h0FF, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrCycle(input logic c, input logic w, input logic [17:0] d);
    @(negedge wrClk);
    cfgMode = c; wrEn = w; rdEn = 0; wrData = d;
    @(posedge wrClk); #1;
  endtask

  task automatic rdCycle(input logic c, input logic r);
    @(negedge rdClk);
    cfgMode = c; rdEn = r; wrEn = 0;
    #1 chk("R9 fifoRead", 32'(fifoRead), 32'(!c && r));
    @(posedge rdClk); #1;
  endtask

  task automatic doReset();
    rstN = 0; #23; rstN = 1; #10;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cfgMode = 0; wrEn = 0; rdEn = 0; wrData = '0;
    doReset();
    chk("R5 empty default", 32'(emptyOffset), 32'h01F);
    chk("R5 full default", 32'(fullOffset), 32'h01F);
    chk("R7 readback reset", 32'(rdWord), 32'h0);

    for (int i = 0; i < 9; i++) begin
      @(negedge wrClk);
      cfgMode = VECS[i].cfg; wrEn = VECS[i].we; rdEn = 0; wrData = VECS[i].d;
      #1 chk("R3 fifoWrite", 32'(fifoWrite), 32'(VECS[i].fw));
      @(posedge wrClk); #1;
      chk("R1 R2 R4 empty", 32'(emptyOffset), 32'(VECS[i].e));
      chk("R1 R2 R4 full", 32'(fullOffset), 32'(VECS[i].f));
    end
    wrCycle(0, 0, '0);

    // R6 R7 readback sequence: empty=001 full=0FF
    rdCycle(1, 1); chk("R6 R7 read empty", 32'(rdWord), 32'h00001);
    rdCycle(1, 1); chk("R6 read full", 32'(rdWord), 32'h000FF);
    rdCycle(0, 1); chk("R6 hold on fifo read", 32'(rdWord), 32'h000FF);
    rdCycle(1, 0); chk("R6 hold no enable", 32'(rdWord), 32'h000FF);
    rdCycle(1, 1); chk("R6 wrap to empty", 32'(rdWord), 32'h00001);
    rdCycle(0, 0);

    // R8 write pointer untouched by reads: it sits at full
    wrCycle(1, 1, 18'h3F222);
    chk("R8 write ptr kept", 32'(fullOffset), 32'h222);
    chk("R8 empty unchanged", 32'(emptyOffset), 32'h001);
    wrCycle(0, 0, '0);
    // R8 read pointer untouched by writes: it sits at full
    rdCycle(1, 1); chk("R8 read ptr kept", 32'(rdWord), 32'h00222);
    rdCycle(0, 0);

    // R5 reset restores defaults and pointers
    doReset();
    chk("R5 empty reset again", 32'(emptyOffset), 32'h01F);
    chk("R5 full reset again", 32'(fullOffset), 32'h01F);
    chk("R7 readback cleared", 32'(rdWord), 32'h0);
    wrCycle(1, 1, 18'h00345);
    chk("R5 write ptr at empty", 32'(emptyOffset), 32'h345);
    chk("R5 full still default", 32'(fullOffset), 32'h01F);
    wrCycle(0, 0, '0);
    rdCycle(1, 1); chk("R5 read ptr at empty", 32'(rdWord), 32'h00345);
    rdCycle(0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule